// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block brings a multiphase voltage regulator up from cold. It drives the digital reference code that a DAC turns into the regulation setpoint. Three qualified flags must all be high before it starts: bias power-on reset, power enable and termination-rail enable. It then waits a fixed time and steps the reference up to a boot level of 1.1 V, one code per tick of an external soft-start oscillator. It parks at that level for a fixed time and until a VID code is reported valid, and samples that code. It then steps the reference to the VID target, less a programmable offset. A fixed time after the target is reached, it raises a ready flag.

The OFF code (all zeros) sends the block into a latched shutdown with the reference at zero. Losing any of the three qualifying flags returns the block to idle at once, from any phase. Until ready is high, the regulator is held in continuous-conduction mode, whatever the light-load request says. One DAC code is 6.25 mV, and code 176 is 1.1 V. All fixed delays are parameters counted in system clock cycles.

Top module: `vr_softstart_seq`

## Requirements
- R1: While any of `por_ok`, `pwr_en`, `vtt_en` is low, `dac_code` is 0, `vr_ready` and `shutdown` are low and `ccm_force` is high; the sequence begins only when all three are high together.
- R2: Once qualified, `dac_code` stays at 0 for `START_DLY_CYC` cycles after the idle cycle before the first ramp begins.
- R3: The first ramp raises `dac_code` by one code per oscillator tick, from 0 up to exactly `BOOT_CODE` (176, i.e. 1.1 V at 6.25 mV per code), and never above it.
- R4: During either ramp, `dac_code` changes only in a cycle following a high `ss_tick`, and by exactly one code.
- R5: The boot level is held for at least `HOLD_CYC` cycles, and after that until `vid_valid` is high; `vid_code` is sampled on the first such cycle.
- R6: A non-OFF VID sets the second-ramp target to `vid_code - OFFSET_STEPS`, saturating at 0; the ramp steps up or down toward it, one code per tick.
- R7: A sampled OFF code (`vid_code == 8'h00`) raises `shutdown` and clears `dac_code` to 0; both stay latched while all three qualifying flags remain high.
- R8: `vr_ready` rises `READY_DLY_CYC` cycles after the cycle in which `dac_code` first equals the second-ramp target, and it stays high with `dac_code` unchanged.
- R9: `ccm_force` is high whenever `vr_ready` is low, whatever `lp_req` is; once ready, `ccm_force` is the inverse of `lp_req`.
- R10: When any qualifying flag falls, the next cycle shows `dac_code` 0, `vr_ready` low and `shutdown` low; this takes priority over every other event in that cycle, and requalifying restarts the full sequence.
- R11: Changes on `vid_code` or `vid_valid` after sampling have no effect on the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Bias supply has passed its power-on-reset threshold |
| pwr_en | input | 1 | Qualified power enable |
| vtt_en | input | 1 | Qualified termination-rail enable |
| vid_code | input | DAC_W | Requested voltage code, 6.25 mV per code |
| vid_valid | input | 1 | VID code has settled and may be sampled |
| ss_tick | input | 1 | One-cycle pulse from the soft-start oscillator |
| lp_req | input | 1 | Light-load (power-state) request |
| dac_code | output | DAC_W | Reference code driven to the DAC |
| vr_ready | output | 1 | Regulator output is up and settled |
| shutdown | output | 1 | Latched shutdown after an OFF code |
| ccm_force | output | 1 | Continuous-conduction mode is forced |

## Verification
Two events can fall in the same cycle, and both collisions are provoked on purpose. In the first, a qualifying flag drops in exactly the cycle the hold phase samples an OFF code. The bench holds `vid_valid` low until its model shows the hold counter is exhausted, then raises `vid_valid` with code 0 and lowers `vtt_en` at the same moment. It expects idle, with `shutdown` low, rather than a latched shutdown. In the second, `lp_req` is held high throughout power-up, so the light-load request coincides with the cycle `vr_ready` rises; `ccm_force` must drop only in that cycle. Every cycle is also compared against a behavioural model, so a late or early step, sample or ready edge shows up as a mismatch.

// File: rtl/sss_pkg.sv
// Package: shared types for the soft-start sequencer.
// Assumes: one encoding of the sequencing phases is used by every module.
package sss_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DELAY  = 3'd1,
        PH_RAMP1  = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RAMP2  = 3'd4,
        PH_RDYDLY = 3'd5,
        PH_READY  = 3'd6,
        PH_SHUT   = 3'd7
    } sss_phase_t;

endpackage

// File: rtl/sss_interval_timer.sv
// Module: interval timer shared by the start delay, the boot hold and the ready delay.
// Does:   counts from 0 after a start pulse and saturates at last_val; expired is high at last_val.
// Assumes: last_val is stable while a phase runs, and start is asserted on phase entry.
module sss_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] last_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == last_val);

    // Purpose: restart on start, otherwise count up until the phase end is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sss_dac_stepper.sv
// Module: DAC reference stepper.
// Does:   holds the DAC code and moves it one code toward tgt on each tick while enabled.
// Assumes: clr has priority; tick is a single-cycle pulse.
module sss_dac_stepper #(
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_en,
    input  logic             tick,
    input  logic [DAC_W-1:0] tgt,
    output logic [DAC_W-1:0] code,
    output logic             at_tgt
);

    assign at_tgt = (code == tgt);

    // Purpose: clear, or take one step toward the target on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (clr) begin
            code <= '0;
        end else if (step_en && tick && !at_tgt) begin
            code <= (code < tgt) ? code + 1'b1 : code - 1'b1;
        end
    end

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (code != $past(code)) && ($past(code) != '0 || code == 1'b1 || code != '0))
        |-> (code == $past(code) + 1'b1 || code == $past(code) - 1'b1 || code == '0)); // R4

    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(step_en && tick)) |=> $stable(code)); // R4

endmodule

// File: rtl/sss_vid_capture.sv
// Module: VID sampler.
// Does:   flags the OFF code on the live bus and latches the offset-adjusted target on capture.
// Assumes: capture is a single-cycle strobe issued once per power-up.
module sss_vid_capture #(
    parameter int DAC_W        = 8,
    parameter int OFF_CODE     = 0,
    parameter int OFFSET_STEPS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [DAC_W-1:0] vid_code,
    output logic             vid_is_off,
    output logic [DAC_W-1:0] tgt_q
);

    localparam logic [DAC_W-1:0] OFS = DAC_W'(OFFSET_STEPS);
    localparam logic [DAC_W-1:0] OFFC = DAC_W'(OFF_CODE);

    assign vid_is_off = (vid_code == OFFC);

    // Purpose: latch the target, less the offset and floored at zero, on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (capture) begin
            tgt_q <= (vid_code > OFS) ? (vid_code - OFS) : '0;
        end
    end

    AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(tgt_q)); // R11

endmodule

// File: rtl/vr_softstart_seq.sv
// Module: soft-start sequencer top.
// Does:   runs idle, delay, boot ramp, boot hold, VID ramp, ready delay and ready;
//         latches shutdown on an OFF code; returns to idle on any lost enable.
// Assumes: the three qualifying flags are already synchronous and debounced, and
//          every cycle count parameter is at least 1.
module vr_softstart_seq
    import sss_pkg::*;
#(
    parameter int DAC_W         = 8,
    parameter int BOOT_CODE     = 176,
    parameter int OFF_CODE      = 0,
    parameter int OFFSET_STEPS  = 0,
    parameter int START_DLY_CYC = 272000,
    parameter int HOLD_CYC      = 17000,
    parameter int READY_DLY_CYC = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             pwr_en,
    input  logic             vtt_en,
    input  logic [DAC_W-1:0] vid_code,
    input  logic             vid_valid,
    input  logic             ss_tick,
    input  logic             lp_req,
    output logic [DAC_W-1:0] dac_code,
    output logic             vr_ready,
    output logic             shutdown,
    output logic             ccm_force
);

    localparam int MAX_A = (START_DLY_CYC > HOLD_CYC) ? START_DLY_CYC : HOLD_CYC;
    localparam int MAX_CYC = (MAX_A > READY_DLY_CYC) ? MAX_A : READY_DLY_CYC;
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [DAC_W-1:0] BOOT = DAC_W'(BOOT_CODE);

    sss_phase_t       ph_q, ph_d;
    logic             en_all;
    logic             tmr_start, tmr_exp;
    logic [CNT_W-1:0] tmr_last;
    logic             cap, dac_clr, step_en, at_tgt, vid_off;
    logic [DAC_W-1:0] vid_tgt, ramp_tgt;

    assign en_all = por_ok && pwr_en && vtt_en;

    // Purpose: select the end count for whichever timed phase is running.
    always_comb begin
        case (ph_q)
            PH_DELAY:  tmr_last = CNT_W'(START_DLY_CYC - 1);
            PH_HOLD:   tmr_last = CNT_W'(HOLD_CYC - 1);
            default:   tmr_last = CNT_W'(READY_DLY_CYC - 1);
        endcase
    end

    // Purpose: pick the ramp target, the boot level first and then the VID target.
    always_comb begin
        ramp_tgt = (ph_q == PH_RAMP1) ? BOOT : vid_tgt;
        step_en  = (ph_q == PH_RAMP1) || (ph_q == PH_RAMP2);
    end

    // Purpose: next phase and per-phase strobes; a lost enable overrides everything.
    always_comb begin
        ph_d      = ph_q;
        tmr_start = 1'b0;
        cap       = 1'b0;
        dac_clr   = 1'b0;
        if (!en_all) begin
            ph_d    = PH_IDLE;
            dac_clr = 1'b1;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    ph_d      = PH_DELAY;
                    tmr_start = 1'b1;
                end
                PH_DELAY: begin
                    if (tmr_exp) ph_d = PH_RAMP1;
                end
                PH_RAMP1: begin
                    if (at_tgt) begin
                        ph_d      = PH_HOLD;
                        tmr_start = 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (tmr_exp && vid_valid) begin
                        if (vid_off) begin
                            ph_d    = PH_SHUT;
                            dac_clr = 1'b1;
                        end else begin
                            ph_d = PH_RAMP2;
                            cap  = 1'b1;
                        end
                    end
                end
                PH_RAMP2: begin
                    if (at_tgt) begin
                        ph_d      = PH_RDYDLY;
                        tmr_start = 1'b1;
                    end
                end
                PH_RDYDLY: begin
                    if (tmr_exp) ph_d = PH_READY;
                end
                default: ph_d = ph_q;
            endcase
        end
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    sss_interval_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .last_val (tmr_last),
        .expired  (tmr_exp)
    );

    sss_dac_stepper #(.DAC_W(DAC_W)) i_stepper (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dac_clr),
        .step_en (step_en),
        .tick    (ss_tick),
        .tgt     (ramp_tgt),
        .code    (dac_code),
        .at_tgt  (at_tgt)
    );

    sss_vid_capture #(
        .DAC_W        (DAC_W),
        .OFF_CODE     (OFF_CODE),
        .OFFSET_STEPS (OFFSET_STEPS)
    ) i_vid (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (cap),
        .vid_code   (vid_code),
        .vid_is_off (vid_off),
        .tgt_q      (vid_tgt)
    );

    assign vr_ready  = (ph_q == PH_READY);
    assign shutdown  = (ph_q == PH_SHUT);
    assign ccm_force = !(vr_ready && lp_req);

    AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all |=> (dac_code == '0 && !vr_ready && !shutdown)); // R10

    AST_DELAY_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DELAY) |-> (dac_code == '0)); // R2

    AST_BOOT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RAMP1) |-> (dac_code <= BOOT)); // R3

    AST_HOLD_AT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_HOLD) |-> (dac_code == BOOT)); // R5

    AST_SHUT_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (dac_code == '0)); // R7

    AST_SHUT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && en_all) |=> shutdown); // R7

    AST_READY_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        vr_ready |-> (dac_code == vid_tgt)); // R8

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_ready && en_all) |=> (vr_ready && $stable(dac_code))); // R8

    AST_CCM_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !vr_ready |-> ccm_force); // R9

endmodule

// File: tb/test_vr_softstart_seq.sv
module test_vr_softstart_seq;

    localparam int DW   = 8;
    localparam int BOOT = 176;
    localparam int OFS  = 2;
    localparam int D1   = 12;
    localparam int HOLD = 6;
    localparam int RDY  = 5;

    localparam int M_IDLE = 0, M_DELAY = 1, M_RAMP1 = 2, M_HOLD = 3,
                   M_RAMP2 = 4, M_RDYDLY = 5, M_READY = 6, M_SHUT = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_ok = 1'b0, pwr_en = 1'b0, vtt_en = 1'b0;
    logic [DW-1:0] vid_code = '0;
    logic          vid_valid = 1'b0;
    logic          ss_tick = 1'b0;
    logic          lp_req = 1'b0;
    logic [DW-1:0] dac_code;
    logic          vr_ready, shutdown, ccm_force;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_st = M_IDLE, m_cnt = 0, m_dac = 0, m_tgt = 0;
    bit m_rdy = 0, m_shut = 0;

    always #2.5 clk = ~clk;

    vr_softstart_seq #(
        .DAC_W(DW), .BOOT_CODE(BOOT), .OFF_CODE(0), .OFFSET_STEPS(OFS),
        .START_DLY_CYC(D1), .HOLD_CYC(HOLD), .READY_DLY_CYC(RDY)
    ) i_vr_softstart_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .pwr_en(pwr_en), .vtt_en(vtt_en),
        .vid_code(vid_code), .vid_valid(vid_valid), .ss_tick(ss_tick), .lp_req(lp_req),
        .dac_code(dac_code), .vr_ready(vr_ready), .shutdown(shutdown), .ccm_force(ccm_force)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n || !(por_ok && pwr_en && vtt_en)) begin
            m_st = M_IDLE; m_dac = 0; m_rdy = 0; m_shut = 0; m_cnt = 0;
        end else begin
            case (m_st)
                M_IDLE:  begin m_st = M_DELAY; m_cnt = 0; end
                M_DELAY: if (m_cnt == D1 - 1) m_st = M_RAMP1; else m_cnt++;
                M_RAMP1: if (m_dac == BOOT) begin m_st = M_HOLD; m_cnt = 0; end
                         else if (ss_tick) m_dac++;
                M_HOLD:  if (m_cnt < HOLD - 1) m_cnt++;
                         else if (vid_valid) begin
                             if (vid_code == 0) begin m_st = M_SHUT; m_shut = 1; m_dac = 0; end
                             else begin
                                 m_tgt = (int'(vid_code) > OFS) ? int'(vid_code) - OFS : 0;
                                 m_st = M_RAMP2;
                             end
                         end
                M_RAMP2: if (m_dac == m_tgt) begin m_st = M_RDYDLY; m_cnt = 0; end
                         else if (ss_tick) m_dac += (m_tgt > m_dac) ? 1 : -1;
                M_RDYDLY: if (m_cnt == RDY - 1) begin m_st = M_READY; m_rdy = 1; end
                          else m_cnt++;
                default: ;
            endcase
        end
    end

    function automatic string phase_req(int st);
        case (st)
            M_IDLE:   return "R1 R10";
            M_DELAY:  return "R2";
            M_RAMP1:  return "R3 R4";
            M_HOLD:   return "R5";
            M_RAMP2:  return "R6 R4";
            M_SHUT:   return "R7";
            default:  return "R8";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(dac_code) == m_dac, {phase_req(m_st), " dac_code"}, dac_code, m_dac);
            check(vr_ready == m_rdy, {phase_req(m_st), " vr_ready"}, vr_ready, m_rdy);
            check(shutdown == m_shut, {phase_req(m_st), " shutdown"}, shutdown, m_shut);
            check(ccm_force == !(m_rdy && lp_req), "R9 ccm_force", ccm_force, !(m_rdy && lp_req));
        end
    end

    // Oscillator ticks at an irregular rate.
    always @(posedge clk) begin
        #1;
        ss_tick = ($urandom_range(0, 2) != 0);
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_phase(input int st);
        for (int i = 0; i < 4000 && m_st != st; i++) step(1);
    endtask

    task automatic enables(input bit v);
        por_ok = v; pwr_en = v; vtt_en = v;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_code == 0 && !vr_ready && !shutdown && ccm_force, "R1 reset state", dac_code, 0);

        // R1: two of three enables is not enough.
        por_ok = 1; pwr_en = 1; vtt_en = 0; lp_req = 1;
        step(30);
        check(dac_code == 0 && ccm_force, "R1 partial enables", dac_code, 0);

        // R2 R3 R5 R6 R8 R9: full power-up, upward second ramp, late VID.
        vid_code = 8'd200; vid_valid = 0;
        vtt_en = 1;
        step(D1);
        check(dac_code == 0, "R2 dac still zero in delay", dac_code, 0);
        wait_phase(M_HOLD);
        step(HOLD + 4);
        check(dac_code == BOOT, "R5 parked at boot awaiting VID", dac_code, BOOT);
        vid_valid = 1;
        wait_phase(M_READY);
        step(1);
        check(vr_ready && dac_code == 198, "R6 R8 ready at VID minus offset", dac_code, 198);
        check(!ccm_force, "R9 light load after ready", ccm_force, 0);
        lp_req = 0; step(1);
        check(ccm_force, "R9 ccm when no request", ccm_force, 1);

        // R10: drop mid ramp, then restart.
        enables(0); step(2); enables(1);
        wait_phase(M_RAMP1); step(20);
        vtt_en = 0; step(1);
        check(dac_code == 0 && !vr_ready, "R10 drop during ramp", dac_code, 0);
        vtt_en = 1;

        // R6 R11: downward ramp, VID already valid, bus changes after sampling.
        vid_code = 8'd120; vid_valid = 1;
        wait_phase(M_RAMP2);
        vid_code = 8'd250; step(3); vid_valid = 0;
        wait_phase(M_READY); step(2);
        check(dac_code == 118, "R11 target unaffected by later VID", dac_code, 118);

        // R7: OFF code latches shutdown.
        enables(0); step(1); enables(1);
        vid_code = 8'd0; vid_valid = 1;
        wait_phase(M_SHUT); step(40);
        check(shutdown && dac_code == 0, "R7 shutdown latched", shutdown, 1);
        pwr_en = 0; step(1);
        check(!shutdown, "R7 R10 shutdown cleared by enable cycle", shutdown, 0);

        // R6 boundary: target equals boot level.
        vid_code = 8'd178; pwr_en = 1;
        wait_phase(M_READY); step(1);
        check(vr_ready && dac_code == BOOT, "R6 target equal to boot", dac_code, BOOT);

        // R10: drop coincides with an OFF-code sample.
        enables(0); step(1); enables(1);
        vid_valid = 0; vid_code = 8'd0;
        wait_phase(M_HOLD);
        for (int i = 0; i < 50 && m_cnt != HOLD - 1; i++) step(1);
        vid_valid = 1; vtt_en = 0;
        step(1);
        check(!shutdown && dac_code == 0, "R10 drop wins over OFF sample", shutdown, 0);
        vtt_en = 1; vid_valid = 0;

        // R6 boundary: saturating target of zero.
        vid_code = 8'd1; vid_valid = 1;
        wait_phase(M_READY); step(1);
        check(vr_ready && dac_code == 0, "R6 saturated target", dac_code, 0);

        step(5);
        done = 1;
        summary();
        $finish;
    end

endmodule